// File: doc/BRIEF.md
# Iterative floating-point multiply unit

This block multiplies two floating-point operands that are already in unpacked form. Each operand is a class code, a sign, a binary exponent and a wide fixed-point mantissa. The mantissa is split into 32-bit words, and its lowest bits are guard bits. The unit first settles the special classes: NaN, infinity and zero. For two ordinary numbers it builds the mantissa product serially, one multiplier bit per clock. Every bit that falls off the bottom of the accumulator is folded into a sticky flag. A multiplier word that is entirely zero costs only one cycle. A final one-bit normalisation brings the product back below 2.0.

A caller presents both operands with a one-cycle `start`. It then waits for the one-cycle `done` pulse and reads the unpacked product and its sticky flag. Rounding and packing to a storage format happen downstream. `busy` is high while an operation is in flight, and a `start` seen during that time is ignored. Result outputs are registered and keep their value until the next operation completes.

Top module: `fmul_iter`

## Requirements
- R1: Class codes are 0 zero, 1 number, 2 infinity, 3 NaN; the operand with the larger code is treated as the heavier one (on a tie the b operand). If the heavier operand is NaN, the result is that operand's class, exponent and mantissa, with sign a_sign XOR b_sign.
- R2: If the heavier operand is infinity and the other is zero, the result is a default NaN: class 3, sign 0, exponent 0, every mantissa bit 1. If the heavier operand is infinity and the other is not zero, the result is that infinity's class, exponent and mantissa with sign a_sign XOR b_sign.
- R3: If the heavier operand is zero (so both are zero), or one is zero and the other a number, the result is class 0, exponent 0, mantissa 0, sign a_sign XOR b_sign.
- R4: For two numbers, each normalised (bit LEAD_BIT set, nothing above it, lowest GUARD bits zero), the pre-normalisation product is floor(Ma*Mb / 2^LEAD_BIT). Mantissa word k occupies bits [32k+31:32k], and word 0 holds the guard bits.
- R5: The sticky output is the OR of every product bit discarded below the result mantissa, including the bit dropped by normalisation.
- R6: If the product is at or above 2^(LEAD_BIT+1), it is shifted right once and the exponent is a_exp+b_exp+1. Otherwise the exponent is a_exp+b_exp. Exponent arithmetic is modulo 2^EXP_W, and the returned mantissa always has bit LEAD_BIT as its highest set bit.
- R7: For two numbers the result class is 1 and the sign is a_sign XOR b_sign.
- R8: For two numbers, `done` comes L cycles after the `start` edge, where L = 1 + S. S is the sum of the following per-word costs of b's mantissa: word 0 costs 1 if zero, else 32-GUARD; each middle word costs 1 if zero, else 32; the top word costs (index of its highest set bit)+1.
- R9: For special cases `done` comes 1 cycle after the `start` edge. `busy` rises the cycle after an accepted `start` and falls in the cycle `done` is high. `done` is high for exactly one cycle.
- R10: A `start` asserted while `busy` is high is ignored: the in-flight result is unchanged and no extra `done` is produced.
- R11: After reset all outputs are 0. Result outputs change only in a cycle where `done` is high and hold their value afterwards.
- R12: The sticky output is 0 for every result whose class is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| a_cls | input | 2 | Class of operand a |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EXP_W | Exponent of operand a |
| a_mant | input | WORD_W*WORDS | Mantissa of operand a |
| b_cls | input | 2 | Class of operand b |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Exponent of operand b |
| b_mant | input | WORD_W*WORDS | Mantissa of operand b |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| r_cls | output | 2 | Result class |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent |
| r_mant | output | WORD_W*WORDS | Result mantissa |
| r_sticky | output | 1 | OR of discarded product bits |

## Verification
The hardest case to reach from the ports is the whole-word shift. It happens when a multiplier word is zero and the accumulator has already picked up nonzero bits: a full accumulator word must then move into sticky in one cycle. The stimulus reaches it by building b mantissas with chosen zero words. One has a nonzero lowest word and a zero word above it. Another has a zero lowest word, a nonzero next word and a zero third word. The reference model checks the mantissa, the sticky flag and the exact latency, and the latency shows whether each word was skipped or stepped bit by bit. A second `start` with different operands is injected mid-operation to show it is dropped.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic [1:0] {
    FC_ZERO = 2'd0,
    FC_NUM  = 2'd1,
    FC_INF  = 2'd2,
    FC_NAN  = 2'd3
  } fclass_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SPEC,
    S_RUN,
    S_NORM
  } fmul_state_e;
endpackage

// File: rtl/fmul_classify.sv
module fmul_classify
  import fmul_pkg::*;
#(
  parameter int MW    = 128,
  parameter int EXP_W = 16
) (
  input  logic [1:0]       a_cls,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MW-1:0]    a_mant,
  input  logic [1:0]       b_cls,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MW-1:0]    b_mant,
  output logic [MW-1:0]    x_mant,
  output logic [MW-1:0]    y_mant,
  output logic [EXP_W-1:0] exp_sum,
  output logic             prod_sign,
  output logic             special,
  output logic [1:0]       sp_cls,
  output logic             sp_sign,
  output logic [EXP_W-1:0] sp_exp,
  output logic [MW-1:0]    sp_mant
);
  logic             swap;
  logic [1:0]       x_cls, y_cls;
  logic [EXP_W-1:0] y_exp;

  always_comb begin
    // heavier class goes to the y side; ties keep b there
    swap      = a_cls > b_cls;
    x_cls     = swap ? b_cls  : a_cls;
    y_cls     = swap ? a_cls  : b_cls;
    x_mant    = swap ? b_mant : a_mant;
    y_mant    = swap ? a_mant : b_mant;
    y_exp     = swap ? a_exp  : b_exp;
    exp_sum   = a_exp + b_exp;
    prod_sign = a_sign ^ b_sign;

    special = 1'b1;
    sp_cls  = y_cls;
    sp_sign = prod_sign;
    sp_exp  = y_exp;
    sp_mant = y_mant;
    case (fclass_e'(y_cls))
      FC_NAN: ;
      FC_INF: begin
        if (fclass_e'(x_cls) == FC_ZERO) begin
          sp_cls  = FC_NAN;
          sp_sign = 1'b0;
          sp_exp  = '0;
          sp_mant = '1;
        end
      end
      default: begin
        if (fclass_e'(x_cls) == FC_ZERO) begin
          sp_cls  = FC_ZERO;
          sp_exp  = '0;
          sp_mant = '0;
        end else begin
          special = 1'b0;
        end
      end
    endcase
  end
endmodule

// File: rtl/fmul_step.sv
module fmul_step #(
  parameter int W  = 32,
  parameter int MW = 128,
  localparam int BW = $clog2(W)
) (
  input  logic [MW:0]   acc,
  input  logic          stk,
  input  logic [MW-1:0] xm,
  input  logic [W-1:0]  word,
  input  logic [BW-1:0] bidx,
  input  logic          first,
  input  logic          top,
  output logic [MW:0]   acc_n,
  output logic          stk_n,
  output logic          adv,
  output logic          last
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         word_move;
  logic [W-1:0] le_mask;
  logic [W-1:0] hi_bits;

  always_comb begin
    word_move = first && (word == '0) && !top;
    le_mask   = ((ONE << bidx) << 1) - ONE;
    hi_bits   = word & ~le_mask;
    if (word_move) begin
      // whole zero word: one shift by W, or none while nothing accumulated
      if (acc == '0) begin
        acc_n = acc;
        stk_n = stk;
      end else begin
        acc_n = acc >> W;
        stk_n = stk | (|acc[W-1:0]);
      end
      adv  = 1'b1;
      last = 1'b0;
    end else begin
      stk_n = stk | acc[0];
      acc_n = (acc >> 1) + (word[bidx] ? {1'b0, xm} : '0);
      adv   = (bidx == BW'(W-1));
      last  = top && (hi_bits == '0);
    end
  end
endmodule

// File: rtl/fmul_norm.sv
module fmul_norm #(
  parameter int MW       = 128,
  parameter int LEAD_BIT = 114,
  parameter int EXP_W    = 16
) (
  input  logic [MW:0]      acc,
  input  logic             stk,
  input  logic [EXP_W-1:0] esum,
  output logic [MW-1:0]    mant,
  output logic             sticky,
  output logic [EXP_W-1:0] exp_o
);
  logic big;
  logic [MW:0] shifted;

  always_comb begin
    big     = |acc[MW:LEAD_BIT+1];
    shifted = acc >> 1;
    if (big) begin
      mant   = shifted[MW-1:0];
      sticky = stk | acc[0];
      exp_o  = esum + EXP_W'(1);
    end else begin
      mant   = acc[MW-1:0];
      sticky = stk;
      exp_o  = esum;
    end
  end
endmodule

// File: rtl/fmul_iter.sv
module fmul_iter
  import fmul_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int GUARD    = 2,
  parameter int LEAD_BIT = 114,
  parameter int EXP_W    = 16,
  localparam int MW      = WORD_W * WORDS,
  localparam int BW      = $clog2(WORD_W),
  localparam int IW      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          a_cls,
  input  logic                a_sign,
  input  logic [EXP_W-1:0]    a_exp,
  input  logic [MW-1:0]       a_mant,
  input  logic [1:0]          b_cls,
  input  logic                b_sign,
  input  logic [EXP_W-1:0]    b_exp,
  input  logic [MW-1:0]       b_mant,
  output logic                busy,
  output logic                done,
  output logic [1:0]          r_cls,
  output logic                r_sign,
  output logic [EXP_W-1:0]    r_exp,
  output logic [MW-1:0]       r_mant,
  output logic                r_sticky
);
  fmul_state_e      state;
  logic [MW:0]      acc_q;
  logic             stk_q;
  logic [MW-1:0]    xm_q, ym_q;
  logic [EXP_W-1:0] esum_q;
  logic [1:0]       cls_q;
  logic             sgn_q;
  logic [IW-1:0]    widx_q;
  logic [BW-1:0]    bidx_q;

  logic [MW-1:0]    c_xm, c_ym, c_spm;
  logic [EXP_W-1:0] c_esum, c_spe;
  logic             c_sign, c_special, c_sps;
  logic [1:0]       c_spc;

  fmul_classify #(.MW(MW), .EXP_W(EXP_W)) u_cls (
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .x_mant(c_xm), .y_mant(c_ym), .exp_sum(c_esum), .prod_sign(c_sign),
    .special(c_special), .sp_cls(c_spc), .sp_sign(c_sps),
    .sp_exp(c_spe), .sp_mant(c_spm)
  );

  logic [WORD_W-1:0] cur_word;
  logic              first_bit, top_word;
  logic [MW:0]       s_acc;
  logic              s_stk, s_adv, s_last;

  always_comb begin
    cur_word  = ym_q[int'(widx_q)*WORD_W +: WORD_W];
    first_bit = (widx_q == '0) ? (bidx_q == BW'(GUARD)) : (bidx_q == '0);
    top_word  = (widx_q == IW'(WORDS-1));
  end

  fmul_step #(.W(WORD_W), .MW(MW)) u_step (
    .acc(acc_q), .stk(stk_q), .xm(xm_q), .word(cur_word), .bidx(bidx_q),
    .first(first_bit), .top(top_word),
    .acc_n(s_acc), .stk_n(s_stk), .adv(s_adv), .last(s_last)
  );

  logic [MW-1:0]    n_mant;
  logic             n_stk;
  logic [EXP_W-1:0] n_exp;

  fmul_norm #(.MW(MW), .LEAD_BIT(LEAD_BIT), .EXP_W(EXP_W)) u_norm (
    .acc(acc_q), .stk(stk_q), .esum(esum_q),
    .mant(n_mant), .sticky(n_stk), .exp_o(n_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      acc_q    <= '0;
      stk_q    <= 1'b0;
      xm_q     <= '0;
      ym_q     <= '0;
      esum_q   <= '0;
      cls_q    <= '0;
      sgn_q    <= 1'b0;
      widx_q   <= '0;
      bidx_q   <= '0;
      r_cls    <= '0;
      r_sign   <= 1'b0;
      r_exp    <= '0;
      r_mant   <= '0;
      r_sticky <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            busy <= 1'b1;
            if (c_special) begin
              state  <= S_SPEC;
              cls_q  <= c_spc;
              sgn_q  <= c_sps;
              esum_q <= c_spe;
              ym_q   <= c_spm;
            end else begin
              state  <= S_RUN;
              cls_q  <= FC_NUM;
              sgn_q  <= c_sign;
              esum_q <= c_esum;
              xm_q   <= c_xm;
              ym_q   <= c_ym;
              acc_q  <= '0;
              stk_q  <= 1'b0;
              widx_q <= '0;
              bidx_q <= BW'(GUARD);
            end
          end
        end
        S_SPEC: begin
          r_cls    <= cls_q;
          r_sign   <= sgn_q;
          r_exp    <= esum_q;
          r_mant   <= ym_q;
          r_sticky <= 1'b0;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= S_IDLE;
        end
        S_RUN: begin
          acc_q <= s_acc;
          stk_q <= s_stk;
          if (s_last) begin
            state <= S_NORM;
          end else if (s_adv) begin
            widx_q <= widx_q + IW'(1);
            bidx_q <= '0;
          end else begin
            bidx_q <= bidx_q + BW'(1);
          end
        end
        default: begin
          r_cls    <= cls_q;
          r_sign   <= sgn_q;
          r_exp    <= n_exp;
          r_mant   <= n_mant;
          r_sticky <= n_stk;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fmul_iter_chk.sv
module fmul_iter_chk #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int LEAD_BIT = 114,
  parameter int EXP_W    = 16,
  localparam int MW      = WORD_W * WORDS
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [1:0]       r_cls,
  input logic             r_sign,
  input logic [EXP_W-1:0] r_exp,
  input logic [MW-1:0]    r_mant,
  input logic             r_sticky
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(r_mant) && $stable(r_cls) && $stable(r_exp)
               && $stable(r_sign) && $stable(r_sticky)));

  assert_special_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (r_cls != 2'd1) |-> !r_sticky);

  assert_norm_range_R6: assert property (@(posedge clk) disable iff (rst)
    (done && r_cls == 2'd1) |-> (r_mant[LEAD_BIT] && (r_mant[MW-1:LEAD_BIT+1] == '0)));
endmodule

bind fmul_iter fmul_iter_chk #(
  .WORD_W(WORD_W), .WORDS(WORDS), .LEAD_BIT(LEAD_BIT), .EXP_W(EXP_W)
) u_chk (.*);

// File: tb/tb_fmul_iter.sv
module tb_fmul_iter;
  localparam int W    = 32;
  localparam int NW   = 4;
  localparam int G    = 2;
  localparam int LEAD = 114;
  localparam int EW   = 16;
  localparam int MW   = W * NW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    a_cls = '0, b_cls = '0;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic          busy, done, r_sign, r_sticky;
  logic [1:0]    r_cls;
  logic [EW-1:0] r_exp;
  logic [MW-1:0] r_mant;

  always #5 clk = ~clk;

  fmul_iter #(.WORD_W(W), .WORDS(NW), .GUARD(G), .LEAD_BIT(LEAD), .EXP_W(EW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .busy(busy), .done(done), .r_cls(r_cls), .r_sign(r_sign),
    .r_exp(r_exp), .r_mant(r_mant), .r_sticky(r_sticky)
  );

  typedef struct {
    logic [1:0]    cls;
    logic          sign;
    logic [EW-1:0] exp;
    logic [MW-1:0] mant;
    logic          stk;
    int            lat;
    int            c0;
    string         tag;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic item_t model(logic [1:0] ac, logic as, logic [EW-1:0] ae, logic [MW-1:0] am,
                                  logic [1:0] bc, logic bs, logic [EW-1:0] be, logic [MW-1:0] bm);
    item_t e;
    logic [1:0] xc, yc;
    logic [EW-1:0] ye;
    logic [MW-1:0] xm, ym;
    logic [2*MW-1:0] p, a;
    int t, h, n, sh;
    bit sw;
    sw = ac > bc;
    xc = sw ? bc : ac;  yc = sw ? ac : bc;
    xm = sw ? bm : am;  ym = sw ? am : bm;
    ye = sw ? ae : be;
    e.sign = as ^ bs; e.stk = 1'b0; e.lat = 1; e.c0 = 0; e.tag = "";
    if (yc == 2'd3) begin
      e.cls = 2'd3; e.exp = ye; e.mant = ym;
    end else if (yc == 2'd2 && xc == 2'd0) begin
      e.cls = 2'd3; e.sign = 1'b0; e.exp = '0; e.mant = '1;
    end else if (yc == 2'd2) begin
      e.cls = 2'd2; e.exp = ye; e.mant = ym;
    end else if (xc == 2'd0) begin
      e.cls = 2'd0; e.exp = '0; e.mant = '0;
    end else begin
      e.cls = 2'd1;
      t = 0;
      for (int i = 0; i < MW; i++) if (ym[i]) t = i;
      sh = t - G;
      p = {{MW{1'b0}}, xm} * {{MW{1'b0}}, ym >> G};
      a = p >> sh;
      e.stk = (p & (((2*MW)'(1) << sh) - (2*MW)'(1))) != '0;
      e.exp = ae + be;
      if (a >= ((2*MW)'(1) << (LEAD + 1))) begin
        e.stk = e.stk | a[0];
        a = a >> 1;
        e.exp = e.exp + EW'(1);
      end
      e.mant = a[MW-1:0];
      n = (ym[W-1:0] == '0) ? 1 : (W - G);
      for (int k = 1; k < NW - 1; k++) n += (ym[k*W +: W] == '0) ? 1 : W;
      h = 0;
      for (int i = 0; i < W; i++) if (ym[(NW-1)*W + i]) h = i;
      n += h + 1;
      e.lat = n + 1;
    end
    return e;
  endfunction

  function automatic logic [MW-1:0] rnd_mant();
    logic [MW-1:0] m;
    for (int k = 0; k < NW; k++) m[k*W +: W] = $urandom;
    for (int i = 0; i < MW; i++) if (i > LEAD || i < G) m[i] = 1'b0;
    m[LEAD] = 1'b1;
    return m;
  endfunction

  task automatic check(bit ok, string tag, logic [MW-1:0] act, logic [MW-1:0] exp_v);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // monitor: pops expected items when the design reports completion
  always @(negedge clk) begin
    if (!rst && done && !finished) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected done", '0, '0);
      end else begin
        item_t e;
        e = q.pop_front();
        check(r_cls == e.cls, {e.tag, " class"}, MW'(r_cls), MW'(e.cls));
        check(r_sign == e.sign, {e.tag, " sign"}, MW'(r_sign), MW'(e.sign));
        check(r_exp == e.exp, {e.tag, " exponent"}, MW'(r_exp), MW'(e.exp));
        check(r_mant == e.mant, {e.tag, " mantissa"}, r_mant, e.mant);
        check(r_sticky == e.stk, {e.tag, " sticky R5 R12"}, MW'(r_sticky), MW'(e.stk));
        check((cyc - e.c0 - 1) == e.lat, {e.tag, " latency R8 R9"},
              MW'(cyc - e.c0 - 1), MW'(e.lat));
        check(!busy, {e.tag, " busy low at done R9"}, MW'(busy), '0);
      end
    end
  end

  task automatic run_op(logic [1:0] ac, logic as, logic [EW-1:0] ae, logic [MW-1:0] am,
                        logic [1:0] bc, logic bs, logic [EW-1:0] be, logic [MW-1:0] bm,
                        string tag, bit poke);
    item_t e;
    e = model(ac, as, ae, am, bc, bs, be, bm);
    e.tag = tag;
    e.c0 = cyc;
    q.push_back(e);
    a_cls = ac; a_sign = as; a_exp = ae; a_mant = am;
    b_cls = bc; b_sign = bs; b_exp = be; b_mant = bm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {tag, " busy after start R9"}, MW'(busy), MW'(1));
    if (poke) begin
      @(negedge clk);
      a_cls = 2'd0; b_cls = 2'd0; a_sign = 1'b1; b_sign = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(r_mant == e.mant && r_cls == e.cls && !done,
          {tag, " hold after done R11"}, r_mant, e.mant);
  endtask

  localparam logic [MW-1:0] ONEV = MW'(1) << LEAD;

  initial begin
    logic [MW-1:0] ma, mb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && r_cls == 0 && r_mant == '0 && r_exp == '0
          && r_sticky == 0 && r_sign == 0, "R11 reset state", r_mant, '0);

    // special cases
    ma = rnd_mant(); mb = rnd_mant();
    run_op(2'd3, 1'b1, 16'h0011, ma, 2'd1, 1'b0, 16'h0003, mb, "R1 nan x num", 1'b0);
    run_op(2'd1, 1'b1, 16'h0011, ma, 2'd3, 1'b1, 16'h0022, mb, "R1 num x nan", 1'b0);
    run_op(2'd3, 1'b0, 16'h0044, ma, 2'd3, 1'b1, 16'h0055, mb, "R1 nan x nan", 1'b0);
    run_op(2'd2, 1'b1, 16'h0007, ma, 2'd0, 1'b1, 16'h0000, '0, "R2 inf x zero", 1'b0);
    run_op(2'd0, 1'b0, 16'h0000, '0, 2'd2, 1'b1, 16'h0009, mb, "R2 zero x inf", 1'b0);
    run_op(2'd1, 1'b1, 16'h0002, ma, 2'd2, 1'b0, 16'h7fff, mb, "R2 num x inf", 1'b0);
    run_op(2'd2, 1'b1, 16'h0003, ma, 2'd2, 1'b1, 16'h0004, mb, "R2 inf x inf", 1'b0);
    run_op(2'd0, 1'b1, 16'h0000, '0, 2'd1, 1'b0, 16'h0010, mb, "R3 zero x num", 1'b0);
    run_op(2'd1, 1'b0, 16'h0010, ma, 2'd0, 1'b1, 16'h0000, '0, "R3 num x zero", 1'b0);
    run_op(2'd0, 1'b1, 16'h0000, '0, 2'd0, 1'b1, 16'h0000, '0, "R3 zero x zero", 1'b0);

    // numbers: exact unity, maximum, zero words, random
    run_op(2'd1, 1'b0, 16'h0001, ONEV, 2'd1, 1'b1, 16'h0002, ONEV, "R4 R7 one x one", 1'b0);
    ma = '0; mb = '0;
    for (int i = G; i <= LEAD; i++) begin ma[i] = 1'b1; mb[i] = 1'b1; end
    run_op(2'd1, 1'b1, 16'h7fff, ma, 2'd1, 1'b1, 16'h0000, mb, "R6 max x max", 1'b0);
    mb = rnd_mant(); mb[W +: W] = '0; mb[0 +: W] = 32'h8000_0004;
    run_op(2'd1, 1'b0, 16'hfff0, rnd_mant(), 2'd1, 1'b0, 16'h0005, mb, "R5 R8 word shift", 1'b0);
    mb = rnd_mant(); mb[0 +: W] = '0; mb[2*W +: W] = '0;
    run_op(2'd1, 1'b1, 16'h0100, rnd_mant(), 2'd1, 1'b0, 16'h0100, mb, "R8 skip then step", 1'b0);
    mb = ONEV; mb[G] = 1'b1;
    run_op(2'd1, 1'b0, 16'h0020, rnd_mant(), 2'd1, 1'b0, 16'h8000, mb, "R5 low bit only", 1'b0);
    run_op(2'd1, 1'b0, 16'h0003, rnd_mant(), 2'd1, 1'b1, 16'h0004, rnd_mant(), "R10 start ignored", 1'b1);
    for (int k = 0; k < 10; k++) begin
      run_op(2'd1, 1'($urandom), EW'($urandom), rnd_mant(),
             2'd1, 1'($urandom), EW'($urandom), rnd_mant(), "R4 R5 R6 random", 1'b0);
    end

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R10 pending items", MW'(q.size()), '0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule